// File: doc/BRIEF.md
# Compare and condition register unit

This unit evaluates one compare per strobe, either on two's-complement integers (signed or unsigned) or on single-precision floating-point values. It writes the four-bit outcome into one of eight fields of a condition register. A separate 32-bit exception register is held alongside. Its sticky summary-overflow flag is copied into the outcome of every integer compare.

Besides compares, the unit accepts three other strobes. One copies a whole field to another field. One merges selected fields from a 32-bit word under an 8-bit mask. One loads the exception register. Both registers are visible in full at the outputs at all times. Every update lands on the rising clock edge after the strobe.

Top module: `cmpcr_unit`

## Requirements
- R1: While `rst_n` is low, both `cr_out` and `xer_out` read all zeros.
- R2: Field n sits in `cr_out[31-4n:28-4n]`. Its bits, from MSB to LSB, are less-than, greater-than, equal and summary/unordered. A compare with `op_signed`=1 orders the operands as two's-complement values.
- R3: With `op_signed`=0 an integer compare orders the operands as unsigned values.
- R4: `op_src` picks the second operand: 0 or 3 uses `op_b`, 1 uses `op_imm` sign-extended to 32 bits, and 2 uses `op_imm` zero-extended.
- R5: The lowest bit of an integer result equals `xer_out[31]` as it stands after the compare's edge. This includes a value loaded by `xer_we` in the same cycle.
- R6: A floating-point compare of two non-NaN single-precision values sets exactly one of less/greater/equal. +0 and -0 compare equal, and infinities order at the extremes.
- R7: If either float operand has an all-ones exponent and a nonzero fraction, the field becomes 4'b0001.
- R8: A compare changes only the field selected by `crf_dst`. With no strobe active, `cr_out` holds its value.
- R9: `mv_valid` copies field `crf_src` into field `crf_dst`, and all other fields keep their values.
- R10: `wr_valid` loads field k from `wr_data` where `wr_mask[k]` is 1. Field k maps to bit k of the mask. Fields whose mask bit is 0 keep their value.
- R11: `xer_we` stores `xer_wdata` bits 31 (summary overflow), 30 (overflow), 29 (carry) and 6:0 (byte count). Bits 28:7 always read zero.
- R12: When several condition-register strobes coincide, a compare wins over a field copy, and a field copy wins over a masked write. The losing strobes leave no trace.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Compare strobe |
| op_is_fp | input | 1 | 1 = floating-point compare, 0 = integer |
| op_signed | input | 1 | Integer ordering: 1 signed, 0 unsigned |
| op_src | input | 2 | Second-operand select (register / signed imm / unsigned imm) |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand (register form) |
| op_imm | input | 16 | Immediate operand |
| crf_dst | input | 3 | Destination field index |
| crf_src | input | 3 | Source field index for the field copy |
| mv_valid | input | 1 | Field copy strobe |
| wr_valid | input | 1 | Masked field write strobe |
| wr_mask | input | 8 | Per-field write enables, bit k for field k |
| wr_data | input | 32 | Data for the masked write |
| xer_we | input | 1 | Exception register load strobe |
| xer_wdata | input | 32 | Exception register load data |
| cr_out | output | 32 | Condition register contents |
| xer_out | output | 32 | Exception register contents |

## Verification
On every cycle the assertions check four things. Reset clears both registers. Reserved exception bits stay zero. A compare sets exactly one ordering bit or the unordered code. Every untargeted field survives a compare, and the whole register holds when idle. The summary bit copied by integer compares is also tied to the exception register on every compare. The actual ordering needs the bench's scenarios and its reference model. That covers signed versus unsigned, immediate extension, signed zeros, infinities and NaN detection. The bench also covers field copies, masked merges and strobe priority.

// File: rtl/cmpcr_pkg.sv
package cmpcr_pkg;

    localparam int FLD_W = 4;
    localparam int XER_W = 32;

    // Implemented exception-register bits: SO, OV, CA and the byte count.
    localparam logic [XER_W-1:0] XER_LIVE = 32'hE000_007F;
    localparam int XER_SO_BIT = XER_W - 1;

    typedef enum logic [1:0] {
        SRC_REG  = 2'd0,
        SRC_SIMM = 2'd1,
        SRC_UIMM = 2'd2,
        SRC_RSVD = 2'd3
    } src_sel_e;

    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } crf_t;

endpackage

// File: rtl/cmpcr_int_cmp.sv
module cmpcr_int_cmp #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         is_signed,
    output logic         lt,
    output logic         gt,
    output logic         eq
);
    always_comb begin
        eq = (a == b);
        if (is_signed) begin
            lt = ($signed(a) < $signed(b));
        end else begin
            lt = (a < b);
        end
        gt = !lt && !eq;
    end
endmodule

// File: rtl/cmpcr_fp_cmp.sv
module cmpcr_fp_cmp #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] a,
    input  logic [EXP_W+FRAC_W:0] b,
    output logic                  lt,
    output logic                  gt,
    output logic                  eq,
    output logic                  un
);
    localparam int W   = EXP_W + FRAC_W + 1;
    localparam int MAG = W - 1;

    logic           sa, sb, nan_a, nan_b, both_zero, mag_lt, mag_eq;
    logic [MAG-1:0] ma, mb;

    always_comb begin
        sa        = a[W-1];
        sb        = b[W-1];
        ma        = a[MAG-1:0];
        mb        = b[MAG-1:0];
        nan_a     = (&a[W-2:FRAC_W]) && (|a[FRAC_W-1:0]);
        nan_b     = (&b[W-2:FRAC_W]) && (|b[FRAC_W-1:0]);
        both_zero = (ma == '0) && (mb == '0);
        mag_lt    = (ma < mb);
        mag_eq    = (ma == mb);
        un        = nan_a || nan_b;
        lt        = 1'b0;
        gt        = 1'b0;
        eq        = 1'b0;
        if (un) begin
            lt = 1'b0;
        end else if (both_zero) begin
            eq = 1'b1;
        end else if (sa != sb) begin
            lt = sa;
            gt = sb;
        end else if (mag_eq) begin
            eq = 1'b1;
        end else if (!sa) begin
            lt = mag_lt;
            gt = !mag_lt;
        end else begin
            lt = !mag_lt;
            gt = mag_lt;
        end
    end
endmodule

// File: rtl/cmpcr_unit.sv
module cmpcr_unit
    import cmpcr_pkg::*;
#(
    parameter int FP_EXP_W  = 8,
    parameter int FP_FRAC_W = 23,
    parameter int IMM_W     = 16,
    parameter int NFLD      = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            op_valid,
    input  logic                            op_is_fp,
    input  logic                            op_signed,
    input  logic [1:0]                      op_src,
    input  logic [FP_EXP_W+FP_FRAC_W:0]     op_a,
    input  logic [FP_EXP_W+FP_FRAC_W:0]     op_b,
    input  logic [IMM_W-1:0]                op_imm,
    input  logic [$clog2(NFLD)-1:0]         crf_dst,
    input  logic [$clog2(NFLD)-1:0]         crf_src,
    input  logic                            mv_valid,
    input  logic                            wr_valid,
    input  logic [NFLD-1:0]                 wr_mask,
    input  logic [NFLD*FLD_W-1:0]           wr_data,
    input  logic                            xer_we,
    input  logic [XER_W-1:0]                xer_wdata,
    output logic [NFLD*FLD_W-1:0]           cr_out,
    output logic [XER_W-1:0]                xer_out
);
    localparam int DW  = FP_EXP_W + FP_FRAC_W + 1;
    localparam int CRW = NFLD * FLD_W;

    typedef struct packed {
        logic [CRW-1:0]   cr;
        logic [XER_W-1:0] xer;
    } state_t;

    state_t          st_d, st_q;
    logic [DW-1:0]   opb_d;
    logic [DW-1:0]   imm_s_d, imm_u_d;
    logic            i_lt, i_gt, i_eq;
    logic            f_lt, f_gt, f_eq, f_un;
    crf_t            res_d;
    logic [CRW-1:0]  merge_d;
    logic [FLD_W-1:0] src_fld_d;

    // Immediate widening; a parameter picks whether padding is needed.
    generate
        if (IMM_W < DW) begin : g_ext
            assign imm_s_d = {{(DW-IMM_W){op_imm[IMM_W-1]}}, op_imm};
            assign imm_u_d = {{(DW-IMM_W){1'b0}}, op_imm};
        end else begin : g_noext
            assign imm_s_d = op_imm[DW-1:0];
            assign imm_u_d = op_imm[DW-1:0];
        end
    endgenerate

    always_comb begin
        case (src_sel_e'(op_src))
            SRC_SIMM: opb_d = imm_s_d;
            SRC_UIMM: opb_d = imm_u_d;
            default:  opb_d = op_b;
        endcase
    end

    cmpcr_int_cmp #(.W(DW)) u_int (
        .a(op_a), .b(opb_d), .is_signed(op_signed),
        .lt(i_lt), .gt(i_gt), .eq(i_eq)
    );

    cmpcr_fp_cmp #(.EXP_W(FP_EXP_W), .FRAC_W(FP_FRAC_W)) u_fp (
        .a(op_a), .b(op_b),
        .lt(f_lt), .gt(f_gt), .eq(f_eq), .un(f_un)
    );

    // Per-field merge for the masked write; field 0 is the top nibble.
    generate
        for (genvar g = 0; g < NFLD; g++) begin : g_merge
            localparam int LO = CRW - FLD_W - FLD_W * g;
            assign merge_d[LO +: FLD_W] = wr_mask[g] ? wr_data[LO +: FLD_W]
                                                     : st_q.cr[LO +: FLD_W];
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (xer_we) begin
            st_d.xer = xer_wdata & XER_LIVE;
        end
        src_fld_d = st_q.cr[CRW - FLD_W - FLD_W * int'(crf_src) +: FLD_W];
        if (op_is_fp) begin
            res_d = '{lt: f_lt, gt: f_gt, eq: f_eq, so: f_un};
        end else begin
            res_d = '{lt: i_lt, gt: i_gt, eq: i_eq, so: st_d.xer[XER_SO_BIT]};
        end
        if (op_valid) begin
            st_d.cr[CRW - FLD_W - FLD_W * int'(crf_dst) +: FLD_W] = res_d;
        end else if (mv_valid) begin
            st_d.cr[CRW - FLD_W - FLD_W * int'(crf_dst) +: FLD_W] = src_fld_d;
        end else if (wr_valid) begin
            st_d.cr = merge_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cr_out  = st_q.cr;
    assign xer_out = st_q.xer;

endmodule

// File: rtl/cmpcr_unit_chk.sv
module cmpcr_unit_chk #(
    parameter int NFLD = 8,
    parameter int CRW  = 32,
    parameter int XW   = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    op_valid,
    input logic                    op_is_fp,
    input logic                    mv_valid,
    input logic                    wr_valid,
    input logic                    xer_we,
    input logic [$clog2(NFLD)-1:0] crf_dst,
    input logic [CRW-1:0]          cr_out,
    input logic [XW-1:0]           xer_out
);
    function automatic logic [3:0] fld(logic [CRW-1:0] v, logic [$clog2(NFLD)-1:0] i);
        return v[CRW - 4 - 4 * int'(i) +: 4];
    endfunction

    function automatic logic [CRW-1:0] fmask(logic [$clog2(NFLD)-1:0] i);
        logic [CRW-1:0] m;
        m = '0;
        m[CRW - 4 - 4 * int'(i) +: 4] = 4'hF;
        return m;
    endfunction

    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (cr_out == '0) && (xer_out == '0));

    // R11
    a_r11_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        xer_out[XW-4:7] == '0);

    // R6, R7
    a_r6_one_ordering: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> ($countones(fld(cr_out, $past(crf_dst))[3:1]) == 1) ||
                     ($past(op_is_fp) && fld(cr_out, $past(crf_dst)) == 4'b0001));

    // R5
    a_r5_so_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_is_fp) |=> fld(cr_out, $past(crf_dst))[0] == xer_out[XW-1]);

    // R8
    a_r8_other_fields: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> ((cr_out ^ $past(cr_out)) & ~fmask($past(crf_dst))) == '0);

    // R8
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && !mv_valid && !wr_valid) |=> $stable(cr_out));

    // R11
    a_r11_xer_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !xer_we |=> $stable(xer_out));

endmodule

bind cmpcr_unit cmpcr_unit_chk #(
    .NFLD(NFLD), .CRW(NFLD * 4), .XW(32)
) u_chk (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_is_fp(op_is_fp),
    .mv_valid(mv_valid), .wr_valid(wr_valid), .xer_we(xer_we),
    .crf_dst(crf_dst), .cr_out(cr_out), .xer_out(xer_out)
);

// File: tb/cmpcr_unit_tb.sv
module cmpcr_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 0, op_is_fp = 0, op_signed = 0;
    logic [1:0]  op_src = 0;
    logic [31:0] op_a = 0, op_b = 0;
    logic [15:0] op_imm = 0;
    logic [2:0]  crf_dst = 0, crf_src = 0;
    logic        mv_valid = 0, wr_valid = 0, xer_we = 0;
    logic [7:0]  wr_mask = 0;
    logic [31:0] wr_data = 0, xer_wdata = 0;
    logic [31:0] cr_out, xer_out;

    int n_chk = 0;
    int n_err = 0;
    logic [31:0] m_cr = 0, m_xer = 0;

    always #10 clk = ~clk;

    cmpcr_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_is_fp(op_is_fp),
        .op_signed(op_signed), .op_src(op_src), .op_a(op_a), .op_b(op_b),
        .op_imm(op_imm), .crf_dst(crf_dst), .crf_src(crf_src),
        .mv_valid(mv_valid), .wr_valid(wr_valid), .wr_mask(wr_mask),
        .wr_data(wr_data), .xer_we(xer_we), .xer_wdata(xer_wdata),
        .cr_out(cr_out), .xer_out(xer_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] ref_int(logic [31:0] a, logic [31:0] b, logic sgn, logic so);
        logic [32:0] ka, kb;
        ka = sgn ? {~a[31], a} : {1'b0, a};
        kb = sgn ? {~b[31], b} : {1'b0, b};
        if (ka < kb)      return {3'b100, so};
        else if (ka > kb) return {3'b010, so};
        else              return {3'b001, so};
    endfunction

    function automatic logic is_nan(logic [31:0] v);
        return (v[30:23] == 8'hFF) && (v[22:0] != 0);
    endfunction

    function automatic logic [31:0] fkey(logic [31:0] v);
        logic [31:0] n;
        n = (v[30:0] == 0) ? 32'h0 : v;
        return n[31] ? ~n : (n | 32'h8000_0000);
    endfunction

    function automatic logic [3:0] ref_fp(logic [31:0] a, logic [31:0] b);
        if (is_nan(a) || is_nan(b))   return 4'b0001;
        if (fkey(a) < fkey(b))        return 4'b1000;
        if (fkey(a) > fkey(b))        return 4'b0100;
        return 4'b0010;
    endfunction

    function automatic logic [31:0] eff_b();
        case (op_src)
            2'd1:    return {{16{op_imm[15]}}, op_imm};
            2'd2:    return {16'h0, op_imm};
            default: return op_b;
        endcase
    endfunction

    function automatic logic [31:0] put_fld(logic [31:0] v, int i, logic [3:0] n);
        logic [31:0] r;
        r = v;
        r[28 - 4 * i +: 4] = n;
        return r;
    endfunction

    // Predict, clock, check at the following negedge, then idle the strobes.
    task automatic apply(input string tag);
        logic [3:0] res;
        if (xer_we) m_xer = xer_wdata & 32'hE000_007F;
        if (op_valid) begin
            res = op_is_fp ? ref_fp(op_a, op_b) : ref_int(op_a, eff_b(), op_signed, m_xer[31]);
            m_cr = put_fld(m_cr, int'(crf_dst), res);
        end else if (mv_valid) begin
            m_cr = put_fld(m_cr, int'(crf_dst), m_cr[28 - 4 * int'(crf_src) +: 4]);
        end else if (wr_valid) begin
            for (int k = 0; k < 8; k++)
                if (wr_mask[k]) m_cr[28 - 4 * k +: 4] = wr_data[28 - 4 * k +: 4];
        end
        @(negedge clk);
        chk({tag, " cr"}, cr_out, m_cr);
        chk({tag, " xer"}, xer_out, m_xer);
        op_valid = 0; mv_valid = 0; wr_valid = 0; xer_we = 0;
    endtask

    task automatic cmp_i(input logic [31:0] a, input logic [31:0] b, input logic sgn,
                         input logic [1:0] src, input logic [15:0] imm, input int dst,
                         input string tag);
        op_valid = 1; op_is_fp = 0; op_a = a; op_b = b; op_signed = sgn;
        op_src = src; op_imm = imm; crf_dst = 3'(dst);
        apply(tag);
    endtask

    task automatic cmp_f(input logic [31:0] a, input logic [31:0] b, input int dst,
                         input string tag);
        op_valid = 1; op_is_fp = 1; op_a = a; op_b = b; op_src = 0; crf_dst = 3'(dst);
        apply(tag);
    endtask

    function automatic logic [31:0] pick_fp();
        case ($urandom_range(0, 9))
            0: return 32'h0000_0000;
            1: return 32'h8000_0000;
            2: return 32'h3F80_0000;
            3: return 32'hBF80_0000;
            4: return 32'h7F80_0000;
            5: return 32'hFF80_0000;
            6: return 32'h7FC0_0000;
            7: return 32'hFF80_0001;
            default: return $urandom();
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R1 reset cr", cr_out, 32'h0);
        chk("R1 reset xer", xer_out, 32'h0);
        rst_n = 1;
        @(negedge clk);

        // R11: reserved bits drop
        xer_we = 1; xer_wdata = 32'hFFFF_FFFF; apply("R11 xer all ones");
        xer_we = 1; xer_wdata = 32'h1FFF_FF85; apply("R11 xer byte count");

        // R2 / R3
        cmp_i(32'hFFFF_FFFF, 32'h1, 1, 0, 0, 0, "R2 signed -1<1");
        cmp_i(32'hFFFF_FFFF, 32'h1, 0, 0, 0, 7, "R3 unsigned max>1");
        cmp_i(32'h8000_0000, 32'h7FFF_FFFF, 1, 3, 0, 3, "R2 minint");
        cmp_i(32'h1234, 32'h1234, 0, 0, 0, 5, "R3 equal");

        // R4
        cmp_i(32'hFFFF_8000, 0, 1, 1, 16'h8000, 1, "R4 simm sext equal");
        cmp_i(32'hFFFF_8000, 0, 1, 2, 16'h8000, 2, "R4 uimm zext less");
        cmp_i(32'h0000_8000, 0, 0, 2, 16'h8000, 4, "R4 uimm equal");

        // R5: SO loaded in the same cycle is what the compare sees
        xer_we = 1; xer_wdata = 32'h8000_0000;
        cmp_i(5, 6, 1, 0, 0, 6, "R5 so same cycle");
        xer_we = 1; xer_wdata = 32'h0;
        cmp_i(5, 6, 1, 0, 0, 6, "R5 so cleared");

        // R6 / R7
        cmp_f(32'h0000_0000, 32'h8000_0000, 0, "R6 +0 eq -0");
        cmp_f(32'h3F80_0000, 32'hBF80_0000, 1, "R6 1 gt -1");
        cmp_f(32'hFF80_0000, 32'hBF80_0000, 2, "R6 -inf lt -1");
        cmp_f(32'hC000_0000, 32'hBF80_0000, 3, "R6 -2 lt -1");
        xer_we = 1; xer_wdata = 32'h8000_0000;
        cmp_f(32'h7FC0_0000, 32'h3F80_0000, 4, "R7 nan a");
        cmp_f(32'h3F80_0000, 32'hFF80_0001, 5, "R7 nan b");
        cmp_f(32'h7F80_0000, 32'h7F80_0000, 6, "R7 inf is not nan");

        // R9
        mv_valid = 1; crf_src = 4; crf_dst = 0; apply("R9 copy 4->0");
        mv_valid = 1; crf_src = 2; crf_dst = 2; apply("R9 copy self");

        // R10
        wr_valid = 1; wr_mask = 8'b1000_0001; wr_data = 32'hA5A5_A5A5; apply("R10 mask ends");
        wr_valid = 1; wr_mask = 8'h00; wr_data = 32'hFFFF_FFFF; apply("R10 empty mask");

        // R12: priority among simultaneous strobes
        wr_valid = 1; wr_mask = 8'hFF; wr_data = 32'h0;
        mv_valid = 1; crf_src = 7;
        cmp_i(3, 9, 0, 0, 0, 1, "R12 compare wins");
        wr_valid = 1; wr_mask = 8'hFF; wr_data = 32'h0;
        mv_valid = 1; crf_src = 0; crf_dst = 3; apply("R12 copy wins");

        // R8: idle cycle holds
        apply("R8 idle");

        // Random mix
        for (int it = 0; it < 3000; it++) begin
            int kind;
            kind = $urandom_range(0, 9);
            xer_we = ($urandom_range(0, 7) == 0);
            xer_wdata = $urandom();
            crf_dst = 3'($urandom());
            crf_src = 3'($urandom());
            case (kind)
                0, 1, 2, 3: begin
                    op_valid = 1; op_is_fp = 0; op_signed = 1'($urandom());
                    op_src = 2'($urandom()); op_imm = 16'($urandom());
                    op_a = $urandom();
                    op_b = ($urandom_range(0, 3) == 0) ? op_a : $urandom();
                    apply("R2 R3 R4 R5 R8 random int");
                end
                4, 5, 6: begin
                    op_valid = 1; op_is_fp = 1; op_src = 0;
                    op_a = pick_fp();
                    op_b = ($urandom_range(0, 3) == 0) ? op_a : pick_fp();
                    apply("R6 R7 R8 random fp");
                end
                7: begin
                    mv_valid = 1; wr_valid = 1'($urandom());
                    wr_mask = 8'($urandom()); wr_data = $urandom();
                    apply("R9 R12 random copy");
                end
                8: begin
                    wr_valid = 1; wr_mask = 8'($urandom()); wr_data = $urandom();
                    apply("R10 random mask");
                end
                default: apply("R8 R11 random idle");
            endcase
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule